// File: doc/BRIEF.md
# Line-Doubled Scanout Timing Controller

This block generates the horizontal and vertical sync levels and an 8-bit pixel stream for a low-resolution raster display. It reads pixels from a byte-addressed framebuffer through a simple read port. Each scanline carries `LINE_PIX` one-byte pixels. Every framebuffer row appears on two consecutive display lines, so a short frame store fills the full picture height.

A horizontal counter advances on a pixel clock enable. A vertical sequencer moves once per line through four regions: back porch, visible, front porch and sync. Only the visible region fetches pixels. The sequencer also keeps the framebuffer row address. It reloads that address at the top of the picture, steps it on every second line and wraps it at the end of the screen. It schedules each vertical sync level change for the next line boundary. All horizontal counts, region line numbers, the screen geometry and the blanking byte are parameters.

Top module: `scan_ctrl`

## Requirements
- R1: Within a visible line, pixel j (0 ≤ j < LINE_PIX) is on `pixel_o` while the horizontal count equals HSTART+j, and its value is the byte stored at row address + j. The read port returns data on the clock after a cycle with `fb_rd_o` high and holds it until the next read. A read happens on an enabled tick at count HSTART-2+j. HSTART must be at least 2.
- R2: `hsync_o` is low while the horizontal count is in [HSYNC_START, HSYNC_END) and high at every other count. The count runs 0..HTOTAL-1 and advances only on `pix_ce_i`. HSYNC_START must be at least HSTART+LINE_PIX.
- R3: Lines are numbered from 0 after reset. The number steps at each horizontal wrap. The regions follow in the order back porch, visible, front porch, sync. Lines VISIBLE_START to VFP_START-1 are visible. When the number would reach VSYNC_END it returns to 0 instead, which gives a frame of VSYNC_END lines.
- R4: On the first visible line the row address is FB_BASE. On each later visible line whose number is even, the row address grows by LINE_PIX. Odd lines keep the previous address, so each row is shown twice.
- R5: When a step would take the row address to FB_BASE + LINE_PIX*FB_ROWS or beyond, the address becomes FB_BASE instead. No read address leaves the screen area.
- R6: `pixel_o` holds the BLANK byte at every count outside the pixel window of a visible line, and on every line outside the visible region.
- R7: `vsync_o` goes low at the start of line VSYNC_START+1. It stays low through line 0 of the next frame and goes high at the start of line 1. It changes only at a line boundary.
- R8: While `rst_ni` is low, `pixel_o` is 0, both syncs are high and `fb_rd_o` is low. These values hold until the first enabled tick. The counters restart at line 0, count 0.
- R9: On a clock with `pix_ce_i` low, `pixel_o`, `hsync_o` and `vsync_o` keep their values and no read is issued.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_ce_i | input | 1 | Pixel clock enable, one pixel per high cycle |
| fb_rd_o | output | 1 | Framebuffer read strobe |
| fb_addr_o | output | ADDR_W | Framebuffer byte address |
| fb_data_i | input | 8 | Read data, valid one clock after the strobe and held |
| pixel_o | output | 8 | Pixel byte |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
On every cycle, assertions check the following:
- the legal region order;
- that the row address stays aligned to a line and inside the screen;
- that the row address and vertical sync move only at line boundaries;
- that the horizontal sync falls at its start count and always coincides with blanking;
- that nothing changes while the enable is low.

The actual pixel values can only be shown by the bench scenarios. These compare every output against a model of line number and count. That covers the two-line row doubling, the wrap back to the base after the last row, and vertical sync spanning into line 0 of the next frame. They run with irregular enables and include resets in mid-line.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  typedef enum logic [1:0] {
    V_BACK  = 2'd0,
    V_VIS   = 2'd1,
    V_FRONT = 2'd2,
    V_SYNC  = 2'd3
  } vreg_e;
endpackage

// File: rtl/scan_htimer.sv
module scan_htimer #(
  parameter int HTOTAL      = 200,
  parameter int HSYNC_START = 176,
  parameter int HSYNC_END   = 196,
  parameter int HCNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  output logic [HCNT_W-1:0] h_cnt_o,
  output logic              line_tick_o,
  output logic              hsync_o
);
  localparam logic [HCNT_W-1:0] H_LAST = HCNT_W'(HTOTAL - 1);
  localparam logic [HCNT_W-1:0] HS_ON  = HCNT_W'(HSYNC_START);
  localparam logic [HCNT_W-1:0] HS_OFF = HCNT_W'(HSYNC_END);

  logic [HCNT_W-1:0] h_nxt;

  assign line_tick_o = ce_i && (h_cnt_o == H_LAST);
  assign h_nxt       = (h_cnt_o == H_LAST) ? '0 : h_cnt_o + HCNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt_o <= '0;
      hsync_o <= 1'b1;
    end else if (ce_i) begin
      h_cnt_o <= h_nxt;
      hsync_o <= !((h_nxt >= HS_ON) && (h_nxt < HS_OFF));
    end
  end

  p_hcnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_cnt_o <= H_LAST);
  p_hsync_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |-> h_cnt_o == HS_ON);
endmodule

// File: rtl/scan_vseq.sv
module scan_vseq
  import vga_scan_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int FB_BASE       = 0,
  parameter int LINE_PIX      = 160,
  parameter int FB_ROWS       = 240,
  parameter int VISIBLE_START = 34,
  parameter int VFP_START     = 514,
  parameter int VSYNC_START   = 523,
  parameter int VSYNC_END     = 525,
  parameter int LCNT_W        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_tick_i,
  output logic              fetch_en_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              vsync_o
);
  localparam logic [LCNT_W-1:0] L_VIS = LCNT_W'(VISIBLE_START);
  localparam logic [LCNT_W-1:0] L_VFP = LCNT_W'(VFP_START);
  localparam logic [LCNT_W-1:0] L_VSS = LCNT_W'(VSYNC_START);
  localparam logic [LCNT_W-1:0] L_VSE = LCNT_W'(VSYNC_END);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(FB_BASE);
  localparam logic [ADDR_W:0]   A_END  = (ADDR_W+1)'(FB_BASE + LINE_PIX * FB_ROWS);
  localparam logic [ADDR_W:0]   A_STEP = (ADDR_W+1)'(LINE_PIX);

  vreg_e             st_q, st_d;
  logic [LCNT_W-1:0] line_q, line_n, line_d;
  logic [ADDR_W-1:0] row_d;
  logic [ADDR_W:0]   row_adv;
  logic              vs_tgt_q, vs_tgt_d;

  always_comb begin
    line_n   = line_q + LCNT_W'(1);
    line_d   = line_n;
    st_d     = st_q;
    row_d    = row_addr_o;
    vs_tgt_d = vs_tgt_q;
    row_adv  = {1'b0, row_addr_o} + A_STEP;
    case (st_q)
      V_BACK: if (line_n >= L_VIS) begin
        st_d  = V_VIS;
        row_d = A_BASE;
      end
      V_VIS: begin
        if (line_n >= L_VFP) st_d = V_FRONT;
        else if (!line_n[0]) row_d = (row_adv >= A_END) ? A_BASE : row_adv[ADDR_W-1:0];
      end
      V_FRONT: if (line_n >= L_VSS) begin
        st_d     = V_SYNC;
        vs_tgt_d = 1'b0;
      end
      default: if (line_n >= L_VSE) begin
        st_d     = V_BACK;
        line_d   = '0;
        vs_tgt_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= V_BACK;
      line_q     <= '0;
      row_addr_o <= A_BASE;
      vs_tgt_q   <= 1'b1;
      vsync_o    <= 1'b1;
    end else if (line_tick_i) begin
      st_q       <= st_d;
      line_q     <= line_d;
      row_addr_o <= row_d;
      vs_tgt_q   <= vs_tgt_d;
      vsync_o    <= vs_tgt_q;   // level lands one boundary later
    end
  end

  assign fetch_en_o = (st_q == V_VIS);

  p_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != $past(st_q)) |->
      (($past(st_q) == V_BACK)  && (st_q == V_VIS))   ||
      (($past(st_q) == V_VIS)   && (st_q == V_FRONT)) ||
      (($past(st_q) == V_FRONT) && (st_q == V_SYNC))  ||
      (($past(st_q) == V_SYNC)  && (st_q == V_BACK)));
  p_row_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(row_addr_o) - FB_BASE) % LINE_PIX) == 0);
  p_row_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_addr_o) |-> $past(line_tick_i));
  p_row_in_screen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, row_addr_o} >= {1'b0, A_BASE}) && ({1'b0, row_addr_o} < A_END));
endmodule

// File: rtl/scan_pixpath.sv
module scan_pixpath #(
  parameter int         ADDR_W   = 16,
  parameter int         HCNT_W   = 8,
  parameter int         HSTART   = 8,
  parameter int         LINE_PIX = 160,
  parameter int         PIX_W    = 8,
  parameter logic [7:0] BLANK    = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [HCNT_W-1:0] h_cnt_i,
  input  logic              fetch_en_i,
  input  logic [ADDR_W-1:0] row_addr_i,
  output logic              fb_rd_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic [PIX_W-1:0]  fb_data_i,
  output logic [PIX_W-1:0]  pixel_o
);
  // read two counts ahead: one clock of port latency, one of output register
  localparam logic [HCNT_W-1:0] RD_LO  = HCNT_W'(HSTART - 2);
  localparam logic [HCNT_W-1:0] RD_HI  = HCNT_W'(HSTART - 2 + LINE_PIX);
  localparam logic [HCNT_W-1:0] CAP_LO = HCNT_W'(HSTART - 1);
  localparam logic [HCNT_W-1:0] CAP_HI = HCNT_W'(HSTART - 1 + LINE_PIX);
  localparam logic [PIX_W-1:0]  BLANK_PX = PIX_W'(BLANK);

  logic [HCNT_W-1:0] rd_off;
  logic              rd_win, cap_win;

  assign rd_off    = h_cnt_i - RD_LO;
  assign rd_win    = (h_cnt_i >= RD_LO) && (h_cnt_i < RD_HI);
  assign cap_win   = (h_cnt_i >= CAP_LO) && (h_cnt_i < CAP_HI);
  assign fb_rd_o   = ce_i && fetch_en_i && rd_win;
  assign fb_addr_o = row_addr_i + ADDR_W'(rd_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pixel_o <= '0;
    else if (ce_i) pixel_o <= (fetch_en_i && cap_win) ? fb_data_i : BLANK_PX;
  end

  p_rd_in_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rd_o |-> (int'(fb_addr_o) - int'(row_addr_i)) < LINE_PIX);
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int         ADDR_W        = 16,
  parameter int         FB_BASE       = 0,
  parameter int         LINE_PIX      = 160,
  parameter int         FB_ROWS       = 240,
  parameter int         HTOTAL        = 200,
  parameter int         HSTART        = 8,
  parameter int         HSYNC_START   = 176,
  parameter int         HSYNC_END     = 196,
  parameter int         VISIBLE_START = 34,
  parameter int         VFP_START     = 514,
  parameter int         VSYNC_START   = 523,
  parameter int         VSYNC_END     = 525,
  parameter logic [7:0] BLANK         = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_ce_i,
  output logic              fb_rd_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic [7:0]        fb_data_i,
  output logic [7:0]        pixel_o,
  output logic              hsync_o,
  output logic              vsync_o
);
  localparam int HCNT_W = $clog2(HTOTAL + 1);
  localparam int LCNT_W = $clog2(VSYNC_END + 1);

  logic [HCNT_W-1:0] h_cnt;
  logic              line_tick;
  logic              fetch_en;
  logic [ADDR_W-1:0] row_addr;

  scan_htimer #(
    .HTOTAL(HTOTAL), .HSYNC_START(HSYNC_START), .HSYNC_END(HSYNC_END), .HCNT_W(HCNT_W)
  ) u_htimer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(pix_ce_i),
    .h_cnt_o(h_cnt), .line_tick_o(line_tick), .hsync_o(hsync_o)
  );

  scan_vseq #(
    .ADDR_W(ADDR_W), .FB_BASE(FB_BASE), .LINE_PIX(LINE_PIX), .FB_ROWS(FB_ROWS),
    .VISIBLE_START(VISIBLE_START), .VFP_START(VFP_START),
    .VSYNC_START(VSYNC_START), .VSYNC_END(VSYNC_END), .LCNT_W(LCNT_W)
  ) u_vseq (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_tick_i(line_tick),
    .fetch_en_o(fetch_en), .row_addr_o(row_addr), .vsync_o(vsync_o)
  );

  scan_pixpath #(
    .ADDR_W(ADDR_W), .HCNT_W(HCNT_W), .HSTART(HSTART), .LINE_PIX(LINE_PIX),
    .PIX_W(8), .BLANK(BLANK)
  ) u_pix (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(pix_ce_i), .h_cnt_i(h_cnt),
    .fetch_en_i(fetch_en), .row_addr_i(row_addr),
    .fb_rd_o(fb_rd_o), .fb_addr_o(fb_addr_o), .fb_data_i(fb_data_i), .pixel_o(pixel_o)
  );

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pix_ce_i) |-> $stable(pixel_o) && $stable(hsync_o) && $stable(vsync_o));
  p_vsync_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_o) |-> h_cnt == '0);
  p_hsync_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> pixel_o == BLANK);
  p_rd_screen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rd_o |-> (int'(fb_addr_o) >= FB_BASE) && (int'(fb_addr_o) < FB_BASE + LINE_PIX * FB_ROWS));
endmodule

// File: tb/scan_ctrl_test.sv
module scan_ctrl_test;
  localparam int AW = 10, BASE = 64, LEN = 160, ROWS = 3;
  localparam int HT = 200, HST = 4, HSS = 170, HSE = 190;
  localparam int VIS = 2, VFP = 12, VSS = 14, VSE = 17;
  localparam logic [7:0] BLK = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pix_ce = 1'b0;
  logic          fb_rd;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_data = 8'h00;
  logic [7:0]    pixel;
  logic          hsync, vsync;
  logic [7:0]    mem [0:1023];

  int errors = 0, checks = 0;
  int hm = 0, lm = 0;
  bit ticked = 0, seen_wrap = 0, ce_last = 0, have_prev = 0;
  logic [7:0] prev_pix;
  logic prev_hs, prev_vs;

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (fb_rd) fb_data <= mem[fb_addr];

  scan_ctrl #(
    .ADDR_W(AW), .FB_BASE(BASE), .LINE_PIX(LEN), .FB_ROWS(ROWS),
    .HTOTAL(HT), .HSTART(HST), .HSYNC_START(HSS), .HSYNC_END(HSE),
    .VISIBLE_START(VIS), .VFP_START(VFP), .VSYNC_START(VSS), .VSYNC_END(VSE), .BLANK(BLK)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_ce_i(pix_ce), .fb_rd_o(fb_rd), .fb_addr_o(fb_addr),
    .fb_data_i(fb_data), .pixel_o(pixel), .hsync_o(hsync), .vsync_o(vsync)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (line %0d count %0d)", tag, act, exp, lm, hm);
    end
  endtask

  function automatic int row_of(input int l, output bit wrapped);
    int r = 0;
    for (int n = VIS + 1; n <= l; n++) if (n % 2 == 0) r++;
    wrapped = (r >= ROWS);
    return BASE + (r % ROWS) * LEN;
  endfunction

  task automatic check_now();
    if (!rst_ni) begin
      chk("R8 pixel", int'(pixel), 0);
      chk("R8 hsync", int'(hsync), 1);
      chk("R8 vsync", int'(vsync), 1);
      chk("R8 read", int'(fb_rd), 0);
    end else begin
      bit wr;
      int ra, e_pix, e_hs, e_vs;
      string tag;
      if (!ticked) begin
        e_pix = 0; e_hs = 1; e_vs = 1; tag = "R8 pixel";
      end else begin
        e_hs = (hm >= HSS && hm < HSE) ? 0 : 1;
        e_vs = ((lm >= VSS + 1) || (lm == 0 && seen_wrap)) ? 0 : 1;
        if (lm >= VIS && lm < VFP) begin
          if (hm >= HST && hm < HST + LEN) begin
            ra = row_of(lm, wr);
            e_pix = int'(mem[ra + hm - HST]);
            if (wr) tag = "R5 pixel";
            else if (ra != BASE || (lm % 2) == 1) tag = "R4 pixel";
            else tag = "R1 pixel";
          end else begin
            e_pix = int'(BLK); tag = "R6 pixel";
          end
        end else begin
          e_pix = int'(BLK); tag = "R3 pixel";
        end
      end
      chk(tag, int'(pixel), e_pix);
      chk("R2 hsync", int'(hsync), e_hs);
      chk("R7 vsync", int'(vsync), e_vs);
      if (have_prev && !ce_last) begin
        chk("R9 pixel hold", int'(pixel), int'(prev_pix));
        chk("R9 hsync hold", int'(hsync), int'(prev_hs));
        chk("R9 vsync hold", int'(vsync), int'(prev_vs));
      end
    end
    prev_pix = pixel; prev_hs = hsync; prev_vs = vsync; have_prev = 1;
  endtask

  task automatic advance();
    ticked = 1;
    if (hm == HT - 1) begin
      hm = 0;
      if (lm + 1 == VSE) begin lm = 0; seen_wrap = 1; end
      else lm = lm + 1;
    end else hm = hm + 1;
  endtask

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      check_now();
      pix_ce = ($urandom_range(99) < pct);
      ce_last = pix_ce;
      @(posedge clk);
      if (ce_last && rst_ni) advance();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; pix_ce = 1'b0; ce_last = 0;
    hm = 0; lm = 0; ticked = 0; seen_wrap = 0; have_prev = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check_now();   // R8 during reset
    end
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 1024; a++) mem[a] = 8'($urandom);
    @(negedge clk);
    do_reset();
    run(11500, 70);    // irregular enable, over two frames incl. row wrap
    do_reset();
    run(337, 100);     // stop mid-line
    do_reset();        // directed reset in the middle of a line
    run(7200, 100);    // dense enable, two frames
    run(2500, 35);     // sparse enable, long holds
    finish_run();
  end
endmodule